// File: doc/BRIEF.md
# Sensor Device-Control Register with Guarded Soft Reset

This block holds the device-control byte of a two-axis motion sensor's digital core. Writes arrive on a simple synchronous port: an address, a data byte and a write strobe. Reads are combinational on the same address. The byte carries four stored controls: filter bypass, self-test enable, self-test direction and Y-axis negation. It also carries two write-only actions. One is a clear-error strobe. The other is a pair of reset bits, and the core's soft reset fires only when those bits are written in one exact three-step order.

The outputs drive the rest of the core:
- a one-cycle soft-reset pulse;
- a one-cycle clear-error strobe;
- a combined high-pass-filter bypass and freeze control, which is also forced while self-test runs;
- the self-test enable and direction;
- the Y-axis sample, negated when requested during self-test.

The self-test enable also serves as the status flag that the core appends to every acceleration result.

Top module: `sensor_ctl_reg`

## Requirements
- R1: Three writes to the register whose bit7/bit6 pairs are 10, then 11, then 01 raise `soft_rst_pulse` for exactly the one cycle after the clock edge that captures the third write. Other bits of these writes do not matter.
- R2: A register write whose bit7 and bit6 are both 0 returns the sequence to its idle step, so that a following 11 or 01 write does not advance it.
- R3: Any register write other than the expected next step restarts detection, and a 10 write always counts as a fresh first step. Writes while `wr_addr` differs from `REG_ADDR` leave both the sequence and the stored fields unchanged.
- R4: After power-on reset, and from the edge that completes the sequence, the register reads 0x00. All stored fields are cleared, and the data of the completing write is discarded.
- R5: Reading at `REG_ADDR` returns bit4 = filter bypass, bit3 = self-test direction, bit2 = self-test enable and bit1 = Y negation, as last written. Bits 7, 6, 5 and 0 read 0. Any other address reads 0x00.
- R6: A register write with bit5 = 1 raises `clr_err_strobe` for the one cycle after the capturing edge. The bit is not stored.
- R7: `hpf_bypass` is high whenever the stored bypass bit or the self-test enable is set.
- R8: `st_enable` and `st_dir` follow stored bits 2 and 3.
- R9: `y_out` equals `y_in` unless both self-test enable and Y negation are set. In that case it is the two's-complement negation of `y_in`, and the most negative input saturates to the most positive value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Register address for writes and reads |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data |
| soft_rst_pulse | output | 1 | One-cycle core soft reset |
| clr_err_strobe | output | 1 | One-cycle clear-error strobe |
| hpf_bypass | output | 1 | High-pass filter bypassed and frozen |
| st_enable | output | 1 | Self-test enable, also the result status flag |
| st_dir | output | 1 | Self-test direction |
| y_in | input | SAMPLE_W | Y-axis sample from the converter path |
| y_out | output | SAMPLE_W | Y-axis sample into the processing chain |

## Verification
The assertions check four things on every cycle:
- the soft-reset pulse lasts one cycle and is always preceded by a completing 01 write;
- the clear-error strobe is always preceded by a write with bit5 set;
- an abort write always leaves the detector idle;
- self-test always forces the filter bypass, and the pulse always coincides with cleared fields.

Whether the ordering rule as a whole is right can only be shown by the bench's scenarios. These run every three-write pattern sequence and long streams against the rule that a pulse follows exactly when the last three patterns were 10, 11, 01. The bench also sweeps the full byte readback and every Y sample under each gating combination.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;
  localparam int DATA_W   = 8;
  localparam int B_RESA   = 7;
  localparam int B_RESB   = 6;
  localparam int B_CLRERR = 5;
  localparam int B_HPFB   = 4;
  localparam int B_STDIR  = 3;
  localparam int B_STEN   = 2;
  localparam int B_YNEG   = 1;

  localparam logic [1:0] PAT_ABORT = 2'b00;
  localparam logic [1:0] PAT_STEP1 = 2'b10;
  localparam logic [1:0] PAT_STEP2 = 2'b11;
  localparam logic [1:0] PAT_STEP3 = 2'b01;

  typedef enum logic [1:0] {SEQ_IDLE = 2'd0, SEQ_HAVE1 = 2'd1, SEQ_HAVE2 = 2'd2} seq_t;

  typedef struct packed {
    logic hpfb;
    logic st_dir;
    logic st_en;
    logic y_neg;
  } ctl_fields_t;

  function automatic logic [1:0] reset_pattern(input logic [DATA_W-1:0] d);
    return {d[B_RESA], d[B_RESB]};
  endfunction

  function automatic logic [DATA_W-1:0] pack_readback(input ctl_fields_t f);
    logic [DATA_W-1:0] r;
    r = '0;
    r[B_HPFB]  = f.hpfb;
    r[B_STDIR] = f.st_dir;
    r[B_STEN]  = f.st_en;
    r[B_YNEG]  = f.y_neg;
    return r;
  endfunction
endpackage

// File: rtl/ctlreg_seq_fsm.sv
module ctlreg_seq_fsm
  import ctlreg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_hit,
  input  logic [1:0] pat,
  output logic       seq_done,
  output seq_t       seq_state
);
  seq_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (wr_hit) begin
      if (pat == PAT_STEP1)                             state_d = SEQ_HAVE1;
      else if (state_q == SEQ_HAVE1 && pat == PAT_STEP2) state_d = SEQ_HAVE2;
      else                                              state_d = SEQ_IDLE;
    end
  end

  assign seq_done  = wr_hit && (state_q == SEQ_HAVE2) && (pat == PAT_STEP3);
  assign seq_state = state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/ctlreg_fields.sv
module ctlreg_fields
  import ctlreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [DATA_W-1:0] wdata,
  input  logic              seq_done,
  output ctl_fields_t       fields,
  output logic              ce_strobe,
  output logic              srst_pulse
);
  ctl_fields_t f_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_q        <= '0;
      ce_strobe  <= 1'b0;
      srst_pulse <= 1'b0;
    end else begin
      ce_strobe  <= wr_hit && wdata[B_CLRERR];
      srst_pulse <= seq_done;
      if (seq_done) begin
        f_q <= '0;
      end else if (wr_hit) begin
        f_q.hpfb   <= wdata[B_HPFB];
        f_q.st_dir <= wdata[B_STDIR];
        f_q.st_en  <= wdata[B_STEN];
        f_q.y_neg  <= wdata[B_YNEG];
      end
    end
  end

  assign fields = f_q;
endmodule

// File: rtl/ctlreg_ypath.sv
module ctlreg_ypath #(
  parameter int SAMPLE_W = 12
) (
  input  logic                flip,
  input  logic [SAMPLE_W-1:0] y_in,
  output logic [SAMPLE_W-1:0] y_out
);
  localparam logic [SAMPLE_W-1:0] MOST_NEG = {1'b1, {(SAMPLE_W-1){1'b0}}};
  localparam logic [SAMPLE_W-1:0] MOST_POS = {1'b0, {(SAMPLE_W-1){1'b1}}};

  function automatic logic [SAMPLE_W-1:0] sat_negate(input logic [SAMPLE_W-1:0] v);
    if (v == MOST_NEG) return MOST_POS;
    return (~v) + 1'b1;
  endfunction

  assign y_out = flip ? sat_negate(y_in) : y_in;
endmodule

// File: rtl/sensor_ctl_reg.sv
module sensor_ctl_reg
  import ctlreg_pkg::*;
#(
  parameter int              ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = 4'h2,
  parameter int              SAMPLE_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [DATA_W-1:0]   rd_data,
  output logic                soft_rst_pulse,
  output logic                clr_err_strobe,
  output logic                hpf_bypass,
  output logic                st_enable,
  output logic                st_dir,
  input  logic [SAMPLE_W-1:0] y_in,
  output logic [SAMPLE_W-1:0] y_out
);
  logic        addr_hit;
  logic        wr_hit;
  logic [1:0]  pat;
  logic        seq_done;
  seq_t        seq_state;
  ctl_fields_t fields;

  assign addr_hit = (wr_addr == REG_ADDR);
  assign wr_hit   = wr_en && addr_hit;
  assign pat      = reset_pattern(wr_data);

  ctlreg_seq_fsm u_seq (
    .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .pat(pat),
    .seq_done(seq_done), .seq_state(seq_state)
  );

  ctlreg_fields u_fields (
    .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .wdata(wr_data),
    .seq_done(seq_done), .fields(fields),
    .ce_strobe(clr_err_strobe), .srst_pulse(soft_rst_pulse)
  );

  ctlreg_ypath #(.SAMPLE_W(SAMPLE_W)) u_ypath (
    .flip(fields.st_en && fields.y_neg), .y_in(y_in), .y_out(y_out)
  );

  assign rd_data    = addr_hit ? pack_readback(fields) : '0;
  assign hpf_bypass = fields.hpfb || fields.st_en;
  assign st_enable  = fields.st_en;
  assign st_dir     = fields.st_dir;
endmodule

// File: rtl/ctlreg_chk.sv
module ctlreg_chk
  import ctlreg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_hit,
  input logic [DATA_W-1:0] wr_data,
  input seq_t              seq_state,
  input logic              soft_rst_pulse,
  input logic              clr_err_strobe,
  input logic              hpf_bypass,
  input logic              st_enable,
  input logic              st_dir,
  input logic [DATA_W-1:0] rd_data
);
  // R1
  pulse_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_pulse |=> !soft_rst_pulse);

  // R1
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_pulse |-> $past(wr_hit && reset_pattern(wr_data) == PAT_STEP3));

  // R2
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && reset_pattern(wr_data) == PAT_ABORT) |=> (seq_state == SEQ_IDLE));

  // R4
  pulse_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_pulse |-> (!st_enable && !st_dir && !hpf_bypass));

  // R6
  clr_err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_err_strobe |-> $past(wr_hit && wr_data[B_CLRERR]));

  // R7
  selftest_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_enable |-> hpf_bypass);
endmodule

bind sensor_ctl_reg ctlreg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .wr_data(wr_data),
  .seq_state(seq_state), .soft_rst_pulse(soft_rst_pulse),
  .clr_err_strobe(clr_err_strobe), .hpf_bypass(hpf_bypass),
  .st_enable(st_enable), .st_dir(st_dir), .rd_data(rd_data)
);

// File: tb/sim_sensor_ctl_reg.sv
module sim_sensor_ctl_reg;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int SW = 12;
  localparam logic [AW-1:0] RADDR = 4'h2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = RADDR;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic soft_rst_pulse, clr_err_strobe, hpf_bypass, st_enable, st_dir;
  logic [SW-1:0] y_in = '0;
  logic [SW-1:0] y_out;

  int tests = 0;
  int fails = 0;
  logic [1:0] h0, h1, h2;   // h2 is most recent pattern
  logic [7:0] exp_reg;

  sensor_ctl_reg #(.ADDR_W(AW), .REG_ADDR(RADDR), .SAMPLE_W(SW)) u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one write, returns at the following falling edge (outputs then hold the post-edge state)
  task automatic do_write(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = RADDR;
  endtask

  // register write with a bench-side model: pulse iff last three patterns are 10,11,01
  task automatic model_write(input logic [7:0] d);
    logic expect_pulse;
    do_write(RADDR, d);
    h0 = h1; h1 = h2; h2 = {d[7], d[6]};
    expect_pulse = (h0 == 2'b10) && (h1 == 2'b11) && (h2 == 2'b01);
    if (expect_pulse) begin
      exp_reg = 8'h00;
      h0 = 2'b00; h1 = 2'b00; h2 = 2'b00;
    end else begin
      exp_reg = d & 8'h1E;
    end
    check("R1 pulse", soft_rst_pulse, expect_pulse);
    check("R4/R5 readback", rd_data, exp_reg);
    check("R6 strobe", clr_err_strobe, d[5]);
    check("R7 bypass", hpf_bypass, exp_reg[4] | exp_reg[2]);
    check("R8 st", {st_dir, st_enable}, {exp_reg[3], exp_reg[2]});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    h0 = 0; h1 = 0; h2 = 0; exp_reg = 0;
    #(CLK_PERIOD * 2 + 2);
    // R4 reset state
    check("R4 reset read", rd_data, 8'h00);
    check("R4 reset pulse", {soft_rst_pulse, clr_err_strobe}, 2'b00);
    rst_n = 1'b1;

    // R5/R6: every byte written from idle (abort before each keeps history clear)
    for (int v = 0; v < 256; v++) begin
      model_write(8'h00);
      model_write(v[7:0]);
      @(negedge clk);
      check("R6 strobe one cycle", clr_err_strobe, 1'b0);
      check("R1 pulse idle", soft_rst_pulse, 1'b0);
    end

    // R1/R2/R3: every three-pattern sequence, mixed other bits
    for (int t = 0; t < 64; t++) begin
      model_write(8'h00);
      model_write({t[5:4], 6'b010110});
      model_write({t[3:2], 6'b101001});
      model_write({t[1:0], 6'b111110});
      @(negedge clk);
      check("R1 pulse ends", soft_rst_pulse, 1'b0);
    end

    // R2: abort in the middle
    model_write(8'h80); model_write(8'hC0); model_write(8'h14); model_write(8'h40);
    check("R2 abort mid", soft_rst_pulse, 1'b0);
    // R3: repeat of step 1 is a fresh step 1
    model_write(8'h80); model_write(8'h80); model_write(8'hC0); model_write(8'h5E);
    check("R3 fresh step1", soft_rst_pulse, 1'b1);
    check("R4 discard data", rd_data, 8'h00);

    // R3: other-address writes ignored, sequence survives them
    model_write(8'h16);
    model_write(8'h80);
    do_write(4'h5, 8'hFF);
    check("R3 other addr fields", rd_data, 8'h00 | (8'h80 & 8'h1E));
    check("R3 other addr strobe", clr_err_strobe, 1'b0);
    model_write(8'hC4);
    do_write(4'h0, 8'h00);
    model_write(8'h40);
    check("R3 seq survives other addr", soft_rst_pulse, 1'b1);
    wr_addr = 4'h7;
    #1;
    check("R5 other addr read", rd_data, 8'h00);
    wr_addr = RADDR;

    // long stream with a deterministic pattern
    for (int k = 0; k < 400; k++) begin
      logic [7:0] d;
      d = 8'((k * 37 + (k >> 3) * 11) ^ (k << 2));
      model_write(d);
    end

    // R9: all samples under each gating combination
    for (int g = 0; g < 4; g++) begin
      model_write({4'b0000, 1'b0, g[1], g[0], 1'b0});
      for (int s = 0; s < (1 << SW); s++) begin
        logic [SW-1:0] e;
        y_in = s[SW-1:0];
        #1;
        if (g == 3) begin
          if (s == (1 << (SW-1))) e = SW'((1 << (SW-1)) - 1);
          else e = SW'(-s);
        end else e = s[SW-1:0];
        check("R9 y path", y_out, e);
      end
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule